// File: doc/BRIEF.md
# Sliding-Window Exponentiation Sequencer

This block steers one full modular exponentiation by handing a sequence of Montgomery-multiply commands to an external multiplier. Each command names two operand slots and one destination slot. The multiplier and the data memories sit outside the block. The sequencer only decides which slots go into each product and when the next product may begin.

A run has three phases:

- **Precompute.** The first command moves the base into Montgomery form. The next forms the Montgomery image of one. The third squares the converted base. After that, the block builds the chain of odd powers into a table of 2^(W-1) slots.
- **Main.** This phase waits until the precompute phase is complete and the external exponent recoder has reported that it has finished. The recoder works in parallel with the precompute phase. The block then reads recoded entries one per step. Each entry becomes one or more squarings of the accumulator, and a window entry adds one multiply by a table slot.
- **Final.** A last multiply by one takes the result out of Montgomery form.

The accumulator starts in the slot that holds the image of one. The block tracks that slot rather than copying it, so the first squaring reads it directly.

Top module: `swx_seq`

## Requirements
- R1: After `start`, the first three commands are, in order: (base, RR) into table slot 0; (one, RR) into the CR slot; (table slot 0, table slot 0) into the X2 slot. Slot codes are: base 0, RR 1, constant one 2, X2 3, CR 4, accumulator SR 5, result Y 6, and odd-power table slot k at 16+k (W = 5). No command ever writes the base, RR or one slots.
- R2: The next 2^(W-1)-1 commands build odd powers in ascending order: table slot k = MM(table slot k-1, X2) for k = 1 to 15.
- R3: No table read and no command into SR happens before `rec_done` has been seen high, and the main phase begins only after the last odd-power command completes. `rec_done` may rise before or after that point.
- R4: A table entry is 8 bits. Bit 7 is the window flag, bits 6:4 are the run length and bits 3:0 are the table index. An entry with flag 0 issues exactly one squaring. The first squaring of a run reads CR for both operands; every later squaring reads SR. The table address stays below `ent_count`.
- R5: A window entry issues as many squarings as its run length, then one MM(table slot index, SR) into SR. A run length of 0 is treated as 1.
- R6: After the last entry, or straight after precompute when `ent_count` is 0, the block issues MM(one, acc) into Y. It then pulses `finish` for one cycle and returns to idle with `busy` low.
- R7: A command stays on `cmd_valid` with unchanged slot fields until `cmd_ack`. No further command is offered until `mm_done` follows that acknowledge.
- R8: The command count for a t-bit exponent recoded with W = 5 is 2^(W-1)+2 plus the squarings and table multiplies, plus one. It does not exceed t + ceil((t+1)/5) + 20.
- R9: `start` while `busy` is ignored, and `mm_done` with no acknowledged command outstanding is ignored.
- R10: During and right after reset, `cmd_valid`, `tbl_rd`, `busy` and `finish` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (used when idle) |
| rec_done | input | 1 | Exponent recoding finished (level or pulse) |
| ent_count | input | CNT_W | Number of recoded entries in the table |
| tbl_rd | output | 1 | Table read strobe; data is expected on the next cycle |
| tbl_addr | output | CNT_W | Table entry address |
| tbl_data | input | ENT_W | Recoded entry returned one cycle after `tbl_rd` |
| cmd_valid | output | 1 | Command offered to the multiplier |
| cmd_ack | input | 1 | Multiplier accepts the offered command |
| cmd_opa | output | SEL_W | First operand slot |
| cmd_opb | output | SEL_W | Second operand slot |
| cmd_dst | output | SEL_W | Destination slot |
| mm_done | input | 1 | Accepted command has finished |
| busy | output | 1 | A run is in progress |
| finish | output | 1 | One-cycle pulse at the end of a run |

## Verification
The assertions check on every cycle:

- the command handshake, with fields held until acceptance and silence while a product is in flight;
- that no write ever targets an input slot;
- the table address range;
- the rule that nothing of the main phase happens before recoding is reported;
- the single-cycle `finish` pulse.

Only the bench scenarios show that the whole command trace is correct. That covers the precompute order and chain indices, the expansion of zero and window entries, the first squaring reading CR, and the final conversion. These scenarios also bring out the count bound over several exponents, the run-length-zero case, and the stray `start` and `mm_done` pulses.

// File: rtl/swx_pkg.sv
package swx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_WREC, ST_FETCH, ST_LOAD,
    ST_SQR, ST_TMUL, ST_FINAL, ST_END
  } st_t;

  typedef enum logic [1:0] {K_PRE, K_SQR, K_TMUL, K_FIN} kind_t;

  localparam int unsigned SLOT_X   = 0;
  localparam int unsigned SLOT_RR  = 1;
  localparam int unsigned SLOT_ONE = 2;
  localparam int unsigned SLOT_X2  = 3;
  localparam int unsigned SLOT_CR  = 4;
  localparam int unsigned SLOT_SR  = 5;
  localparam int unsigned SLOT_Y   = 6;

  // squarings implied by one recoded entry
  function automatic int unsigned sq_run(input logic win, input int unsigned len);
    return (win && len != 0) ? len : 1;
  endfunction

endpackage

// File: rtl/swx_cmdgen.sv
module swx_cmdgen
  import swx_pkg::*;
#(
  parameter int W     = 5,
  parameter int SEL_W = 5,
  parameter int PS_W  = 5,
  parameter int IDX_W = 4
) (
  input  kind_t              kind,
  input  logic [PS_W-1:0]    pstep,
  input  logic [IDX_W-1:0]   widx,
  input  logic               acc_cr,
  output logic [SEL_W-1:0]   opa,
  output logic [SEL_W-1:0]   opb,
  output logic [SEL_W-1:0]   dst
);
  localparam int unsigned ODD_BASE = 1 << (SEL_W - 1);

  logic [SEL_W-1:0] acc;
  assign acc = acc_cr ? SEL_W'(SLOT_CR) : SEL_W'(SLOT_SR);

  always_comb begin
    opa = '0;
    opb = '0;
    dst = '0;
    unique case (kind)
      K_PRE: begin
        if (pstep == PS_W'(0)) begin
          opa = SEL_W'(SLOT_X);   opb = SEL_W'(SLOT_RR); dst = SEL_W'(ODD_BASE);
        end else if (pstep == PS_W'(1)) begin
          opa = SEL_W'(SLOT_ONE); opb = SEL_W'(SLOT_RR); dst = SEL_W'(SLOT_CR);
        end else if (pstep == PS_W'(2)) begin
          opa = SEL_W'(ODD_BASE); opb = SEL_W'(ODD_BASE); dst = SEL_W'(SLOT_X2);
        end else begin
          opa = SEL_W'(ODD_BASE) + SEL_W'(pstep) - SEL_W'(3);
          opb = SEL_W'(SLOT_X2);
          dst = SEL_W'(ODD_BASE) + SEL_W'(pstep) - SEL_W'(2);
        end
      end
      K_SQR: begin
        opa = acc; opb = acc; dst = SEL_W'(SLOT_SR);
      end
      K_TMUL: begin
        opa = SEL_W'(ODD_BASE) + SEL_W'(widx);
        opb = SEL_W'(SLOT_SR);
        dst = SEL_W'(SLOT_SR);
      end
      default: begin
        opa = SEL_W'(SLOT_ONE); opb = acc; dst = SEL_W'(SLOT_Y);
      end
    endcase
  end
endmodule

// File: rtl/swx_link.sv
module swx_link #(
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [SEL_W-1:0] in_opa,
  input  logic [SEL_W-1:0] in_opb,
  input  logic [SEL_W-1:0] in_dst,
  input  logic             cmd_ack,
  input  logic             mm_done,
  output logic             cmd_valid,
  output logic [SEL_W-1:0] cmd_opa,
  output logic [SEL_W-1:0] cmd_opb,
  output logic [SEL_W-1:0] cmd_dst,
  output logic             complete
);
  logic waiting;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      waiting   <= 1'b0;
      cmd_opa   <= '0;
      cmd_opb   <= '0;
      cmd_dst   <= '0;
    end else if (fire && !cmd_valid && !waiting) begin
      cmd_valid <= 1'b1;
      cmd_opa   <= in_opa;
      cmd_opb   <= in_opb;
      cmd_dst   <= in_dst;
    end else if (cmd_valid && cmd_ack) begin
      cmd_valid <= 1'b0;
      waiting   <= 1'b1;
    end else if (waiting && mm_done) begin
      waiting   <= 1'b0;
    end
  end

  // done only counts after an acknowledged command
  assign complete = waiting && mm_done;

  assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_opa) && $stable(cmd_opb) && $stable(cmd_dst));

  assert_quiet_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !cmd_valid);

endmodule

// File: rtl/swx_seq.sv
module swx_seq
  import swx_pkg::*;
#(
  parameter int W       = 5,
  parameter int MAX_ENT = 4096,
  localparam int TBL    = 1 << (W - 1),
  localparam int IDX_W  = W - 1,
  localparam int LEN_W  = $clog2(W + 1),
  localparam int ENT_W  = 1 + LEN_W + IDX_W,
  localparam int SEL_W  = ((IDX_W > 3) ? IDX_W : 3) + 1,
  localparam int CNT_W  = $clog2(MAX_ENT + 1),
  localparam int PS_W   = $clog2(TBL + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rec_done,
  input  logic [CNT_W-1:0] ent_count,
  output logic             tbl_rd,
  output logic [CNT_W-1:0] tbl_addr,
  input  logic [ENT_W-1:0] tbl_data,
  output logic             cmd_valid,
  input  logic             cmd_ack,
  output logic [SEL_W-1:0] cmd_opa,
  output logic [SEL_W-1:0] cmd_opb,
  output logic [SEL_W-1:0] cmd_dst,
  input  logic             mm_done,
  output logic             busy,
  output logic             finish
);
  localparam int LAST_PRE = TBL + 1;

  st_t              st;
  logic             issued, acc_cr, rec_seen, is_win;
  logic [PS_W-1:0]  pstep;
  logic [CNT_W-1:0] eidx, n_ent_q;
  logic [LEN_W-1:0] sq_left;
  logic [IDX_W-1:0] widx;

  kind_t            kind;
  logic             cmd_state, fire, cmd_end, last_ent;
  logic [SEL_W-1:0] g_opa, g_opb, g_dst;

  assign cmd_state = (st == ST_PRE) || (st == ST_SQR) || (st == ST_TMUL) || (st == ST_FINAL);
  assign fire      = cmd_state && !issued;
  assign last_ent  = (eidx == n_ent_q - 1'b1);
  assign busy      = (st != ST_IDLE);
  assign finish    = (st == ST_END);
  assign tbl_rd    = (st == ST_FETCH);
  assign tbl_addr  = eidx;

  always_comb begin
    unique case (st)
      ST_PRE:  kind = K_PRE;
      ST_SQR:  kind = K_SQR;
      ST_TMUL: kind = K_TMUL;
      default: kind = K_FIN;
    endcase
  end

  swx_cmdgen #(.W(W), .SEL_W(SEL_W), .PS_W(PS_W), .IDX_W(IDX_W)) u_gen (
    .kind(kind), .pstep(pstep), .widx(widx), .acc_cr(acc_cr),
    .opa(g_opa), .opb(g_opb), .dst(g_dst)
  );

  swx_link #(.SEL_W(SEL_W)) u_link (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .in_opa(g_opa), .in_opb(g_opb), .in_dst(g_dst),
    .cmd_ack(cmd_ack), .mm_done(mm_done),
    .cmd_valid(cmd_valid), .cmd_opa(cmd_opa), .cmd_opb(cmd_opb), .cmd_dst(cmd_dst),
    .complete(cmd_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      issued   <= 1'b0;
      acc_cr   <= 1'b1;
      rec_seen <= 1'b0;
      is_win   <= 1'b0;
      pstep    <= '0;
      eidx     <= '0;
      n_ent_q  <= '0;
      sq_left  <= '0;
      widx     <= '0;
    end else begin
      if (cmd_end)   issued <= 1'b0;
      else if (fire) issued <= 1'b1;

      if (st == ST_IDLE)  rec_seen <= 1'b0;
      else if (rec_done)  rec_seen <= 1'b1;

      unique case (st)
        ST_IDLE: if (start) begin
          st      <= ST_PRE;
          pstep   <= '0;
          eidx    <= '0;
          acc_cr  <= 1'b1;
          n_ent_q <= ent_count;
        end
        ST_PRE: if (cmd_end) begin
          if (pstep == PS_W'(LAST_PRE)) st <= ST_WREC;
          else pstep <= pstep + 1'b1;
        end
        ST_WREC: if (rec_seen || rec_done)
          st <= (n_ent_q == '0) ? ST_FINAL : ST_FETCH;
        ST_FETCH: st <= ST_LOAD;
        ST_LOAD: begin
          is_win  <= tbl_data[ENT_W-1];
          widx    <= tbl_data[IDX_W-1:0];
          sq_left <= LEN_W'(sq_run(tbl_data[ENT_W-1], int'(tbl_data[IDX_W +: LEN_W])));
          st      <= ST_SQR;
        end
        ST_SQR: if (cmd_end) begin
          acc_cr <= 1'b0;
          if (sq_left == LEN_W'(1)) begin
            if (is_win)        st <= ST_TMUL;
            else if (last_ent) st <= ST_FINAL;
            else begin eidx <= eidx + 1'b1; st <= ST_FETCH; end
          end else begin
            sq_left <= sq_left - 1'b1;
          end
        end
        ST_TMUL: if (cmd_end) begin
          if (last_ent) st <= ST_FINAL;
          else begin eidx <= eidx + 1'b1; st <= ST_FETCH; end
        end
        ST_FINAL: if (cmd_end) st <= ST_END;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assert_no_input_slot_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_dst != SEL_W'(SLOT_X)) && (cmd_dst != SEL_W'(SLOT_RR)) && (cmd_dst != SEL_W'(SLOT_ONE)));

  assert_main_after_recode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd || (cmd_valid && cmd_dst == SEL_W'(SLOT_SR))) |-> rec_seen);

  assert_addr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd |-> (tbl_addr < n_ent_q));

  assert_finish_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !finish && !busy);

endmodule

// File: tb/tb_swx_seq.sv
`timescale 1ns/1ps
module tb_swx_seq;
  localparam int W     = 5;
  localparam int TBL   = 16;
  localparam int ENT_W = 8;
  localparam int MAXE  = 4096;
  localparam int CNT_W = 13;
  localparam int SEL_W = 5;
  localparam int OB    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rec_done = 1'b0;
  logic [CNT_W-1:0] ent_count = '0;
  logic tbl_rd;
  logic [CNT_W-1:0] tbl_addr;
  logic [ENT_W-1:0] tbl_data = '0;
  logic cmd_valid, cmd_ack, mm_done;
  logic [SEL_W-1:0] cmd_opa, cmd_opb, cmd_dst;
  logic busy, finish;

  always #2 clk = ~clk;

  swx_seq #(.W(W), .MAX_ENT(MAXE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rec_done(rec_done), .ent_count(ent_count),
    .tbl_rd(tbl_rd), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .cmd_valid(cmd_valid), .cmd_ack(cmd_ack), .cmd_opa(cmd_opa), .cmd_opb(cmd_opb),
    .cmd_dst(cmd_dst), .mm_done(mm_done), .busy(busy), .finish(finish)
  );

  int n_cmp = 0, n_bad = 0;
  logic [ENT_W-1:0] tmem [0:63];
  int n_ent, t_bits;
  int ea [0:255];
  int ne;
  int tr [0:255];
  int n_tr, hold_bad;
  int m_ack = 0, m_lat = 0;
  bit m_stray = 0;

  always @(posedge clk) if (tbl_rd) tbl_data <= tmem[tbl_addr[5:0]];

  // exponent vector: exp, ack delay, done latency, rec_done delay, stray pulses
  localparam logic [40:0] VEC [0:5] = '{
    {24'h000000, 4'd0, 4'd1, 8'd1,   1'b0},
    {24'h000001, 4'd1, 4'd0, 8'd3,   1'b0},
    {24'hB5F3A1, 4'd0, 4'd2, 8'd10,  1'b0},
    {24'hFFFFFF, 4'd2, 4'd1, 8'd1,   1'b0},
    {24'h800001, 4'd1, 4'd3, 8'd50,  1'b0},
    {24'h5A5A5A, 4'd2, 4'd2, 8'd200, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pk(input int a, input int b, input int d);
    return (a << 10) | (b << 5) | d;
  endfunction

  // behavioural multiplier: accept after m_ack cycles, finish after m_lat more
  initial begin
    int ca, cb, cd;
    cmd_ack = 0; mm_done = 0;
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid && !cmd_ack) begin
        ca = cmd_opa; cb = cmd_opb; cd = cmd_dst;
        for (int k = 0; k < m_ack; k++) begin
          mm_done = m_stray;
          @(negedge clk);
          if (!cmd_valid || cmd_opa != ca || cmd_opb != cb || cmd_dst != cd) hold_bad++;
        end
        mm_done = 0;
        cmd_ack = 1;
        if (n_tr < 256) tr[n_tr] = pk(ca, cb, cd);
        n_tr++;
        @(negedge clk);
        cmd_ack = 0;
        for (int k = 0; k < m_lat; k++) @(negedge clk);
        mm_done = 1;
        @(negedge clk);
        mm_done = 0;
      end
    end
  end

  task automatic recode(input logic [23:0] e);
    int i, l, v;
    n_ent = 0; t_bits = 0;
    for (int b = 0; b < 24; b++) if (e[b]) t_bits = b + 1;
    i = t_bits - 1;
    while (i >= 0) begin
      if (!e[i]) begin
        tmem[n_ent] = 8'h00; n_ent++; i--;
      end else begin
        l = (i - W + 1 < 0) ? 0 : i - W + 1;
        while (!e[l]) l++;
        v = 0;
        for (int b = i; b >= l; b--) v = (v << 1) | int'(e[b]);
        tmem[n_ent] = {1'b1, 3'(i - l + 1), 4'((v - 1) / 2)};
        n_ent++; i = l - 1;
      end
    end
  endtask

  task automatic push(input int a, input int b, input int d);
    ea[ne] = pk(a, b, d); ne++;
  endtask

  task automatic expect_trace();
    int acc, n;
    ne = 0;
    push(0, 1, OB); push(2, 1, 4); push(OB, OB, 3);
    for (int k = 1; k < TBL; k++) push(OB + k - 1, 3, OB + k);
    acc = 4;
    for (int j = 0; j < n_ent; j++) begin
      n = (tmem[j][7] && tmem[j][6:4] != 0) ? int'(tmem[j][6:4]) : 1;
      for (int s = 0; s < n; s++) begin push(acc, acc, 5); acc = 5; end
      if (tmem[j][7]) push(OB + int'(tmem[j][3:0]), 5, 5);
    end
    push(2, acc, 6);
  endtask

  function automatic string tag_of(input int i, input int last);
    if (i < 3) return "R1 precompute head";
    if (i < TBL + 2) return "R2 odd chain";
    if (i == last) return "R6 final conversion";
    return "R4 R5 main phase";
  endfunction

  task automatic run(input logic [23:0] e, input int ak, input int lat, input int rd,
                     input bit stray, input bit manual);
    int cyc, viol;
    bit got;
    if (!manual) recode(e);
    expect_trace();
    ent_count = CNT_W'(n_ent);
    n_tr = 0; hold_bad = 0; viol = 0;
    m_ack = ak; m_lat = lat; m_stray = stray;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    cyc = 0; got = 0;
    while (!got && cyc < 20000) begin
      @(negedge clk); cyc++;
      if (cyc == rd) rec_done = 1;
      start = stray && (cyc == 40);   // R9: start while busy
      if (!rec_done && (tbl_rd || (cmd_valid && cmd_dst == 5))) viol++;
      if (finish) got = 1;
    end
    start = 0;
    check(got, "R6 finish pulse seen", int'(got), 1);
    @(negedge clk);
    check(!busy && !finish, "R6 idle after finish", int'({busy, finish}), 0);
    check(viol == 0, "R3 main phase before rec_done", viol, 0);
    check(hold_bad == 0, "R7 command held until ack", hold_bad, 0);
    check(n_tr == ne, "R8 command count", n_tr, ne);
    for (int i = 0; i < ne && i < n_tr; i++)
      check(tr[i] == ea[i], tag_of(i, ne - 1), tr[i], ea[i]);
    if (!manual)
      check(n_tr <= t_bits + (t_bits + 5) / 5 + 20, "R8 count bound", n_tr,
            t_bits + (t_bits + 5) / 5 + 20);
    rec_done = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!cmd_valid && !tbl_rd && !busy && !finish, "R10 in reset",
          int'({cmd_valid, tbl_rd, busy, finish}), 0);
    rst_n = 1;
    @(negedge clk);
    check(!cmd_valid && !tbl_rd && !busy && !finish, "R10 after reset",
          int'({cmd_valid, tbl_rd, busy, finish}), 0);
    // R9: stray done while nothing is outstanding
    force_stray_done();
    check(!cmd_valid && !busy, "R9 stray done ignored", int'({cmd_valid, busy}), 0);

    for (int v = 0; v < 6; v++)
      run(VEC[v][40:17], int'(VEC[v][16:13]), int'(VEC[v][12:9]), int'(VEC[v][8:1]),
          VEC[v][0], 1'b0);

    // R5: run length zero counts as one; mixed entries
    tmem[0] = {1'b1, 3'd0, 4'd3};
    tmem[1] = 8'h00;
    tmem[2] = {1'b1, 3'd2, 4'd15};
    n_ent = 3;
    run(24'h0, 1, 1, 5, 1'b0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic force_stray_done();
    mm_done = 1;
    @(negedge clk);
    mm_done = 0;
    @(negedge clk);
  endtask

endmodule